// File: doc/BRIEF.md
# Ring Slot Pop Sequencer

This block is the consumer-side controller for a ring of fixed-size tile slots shared with a producer core. Each accepted pop request runs a fixed sequence. First it waits for the producer's ready event. It then transfers the current slot, and finally raises a release event so that the producer may refill the slot. The block owns the read-slot counter, and it forms the slot address from a base, the slot index and the slot size.

Events are single-cycle pulses on a flag vector. A pop blocks on flag `FLAG_ID` and releases on flag `FLAG_ID+1`. When the consumer is the second sub-block, both flag numbers are raised by 16. A ready pulse that arrives early is kept as a pending bit, so it is not lost. The wait and release phases can each be skipped per pop.

Three transfer modes exist:
- A tile-load mode issues a memory read of a whole slot, or of half a slot for a split sub-tile.
- A direct local mode issues no read and only binds the local slot address.
- A control mode reads one 32-bit word and latches it.

Top module: `ring_pop_sequencer`

## Requirements
- R1: A pop is accepted only while `pop_ready` is high. Its phases run strictly as wait, then transfer, then release, then a done cycle. A request seen while busy is ignored. `rd_req` stays high until `rd_ack`.
- R2: The wait phase completes only on a ready event on flag `FLAG_ID` (sub-block 0) or `FLAG_ID+16` (sub-block 1). Events on other flags do not end it, and there is no timeout.
- R3: The release phase pulses exactly one bit of `evt_out` for one cycle: bit `FLAG_ID+1` for sub-block 0, or bit `FLAG_ID+17` for sub-block 1.
- R4: The slot index is the number of completed pops modulo `SLOT_COUNT`. In tile mode, `rd_addr` = `TILE_BASE` + index × `SLOT_BYTES`.
- R5: When `pop_split`=1, `rd_len` is `SLOT_BYTES/2`. If `pop_sub`=1 as well, `SLOT_BYTES/2` is added to the address. Otherwise `rd_len` is `SLOT_BYTES`.
- R6: When `pop_wait_en`=0, the wait phase is skipped. The transfer starts in the cycle after acceptance.
- R7: When `pop_free_en`=0, no release event is issued. Done follows the cycle in which the transfer completes.
- R8: A ready event that arrives while the block is not waiting is latched per flag. It is consumed by exactly one later wait on that flag.
- R9: `pop_mode`=2 is control mode. It reads 4 bytes at `CTRL_BASE` + 4 × index and latches `rd_data` into `ctrl_word` on `rd_ack`. `ctrl_word` resets to 0.
- R10: `pop_mode`=1 is direct local mode. It raises no `rd_req`, and `slot_addr` becomes `LOCAL_BASE` + index × `SLOT_BYTES`, plus the split offset. In every mode, `slot_addr` holds the address of the current pop by its done cycle. Modes 0 and 3 are tile load.
- R11: `pop_done` is a one-cycle pulse, one cycle after the release pulse, and `pop_ready` returns in the next cycle. After reset the block is ready, with no event, read or done asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pop_req | input | 1 | Pop request |
| pop_wait_en | input | 1 | Run the wait phase |
| pop_free_en | input | 1 | Run the release phase |
| pop_mode | input | 2 | 0/3 tile load, 1 direct local, 2 control word |
| pop_sub | input | 1 | Consumer sub-block ID |
| pop_split | input | 1 | Transfer a half-slot sub-tile |
| pop_ready | output | 1 | Idle, can accept a pop |
| pop_done | output | 1 | Pop finished (one-cycle pulse) |
| evt_in | input | NUM_FLAGS | Ready event pulses from the producer |
| evt_out | output | NUM_FLAGS | Release event pulses to the producer |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_len | output | LEN_W | Read length in bytes |
| rd_ack | input | 1 | Read acknowledge |
| rd_data | input | 32 | Read word for control mode |
| slot_addr | output | ADDR_W | Address bound for the current pop |
| ctrl_word | output | 32 | Latched control word |

## Verification
The in-line assertions check the following on every cycle:
- a read request is held until it is acknowledged;
- a wait that has no matching event stays in place;
- pending bits survive while they are not being consumed;
- the slot index stays in range and only moves on done;
- the release vector is one-hot and lasts a single cycle;
- done is a single pulse that is followed by ready.

The ordering of whole sequences can only be shown by the bench's scenarios. These include:
- a ready event delivered before the pop;
- an event on the other sub-block's flag during a wait;
- skipped phases;
- a held request during back-to-back pops;
- address wrap over several ring turns.

The bench's reference model also checks the value latched in control mode.

// File: rtl/rps_pkg.sv
package rps_pkg;

   typedef enum logic [1:0] {
      MODE_TILE  = 2'd0,
      MODE_LOCAL = 2'd1,
      MODE_CTRL  = 2'd2,
      MODE_RSVD  = 2'd3
   } pop_mode_e;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_WAIT = 3'd1,
      PH_LOAD = 3'd2,
      PH_FREE = 3'd3,
      PH_DONE = 3'd4
   } phase_e;

   typedef struct packed {
      logic      wait_en;
      logic      free_en;
      pop_mode_e mode;
      logic      sub;
      logic      split;
   } pop_cfg_t;

endpackage

// File: rtl/rps_event_latch.sv
module rps_event_latch #(
   parameter int NUM_FLAGS = 32,
   localparam int FLAG_W   = $clog2(NUM_FLAGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] evt_in,
   input  logic [FLAG_W-1:0]    sel,
   input  logic                 probe,
   output logic                 hit
);
   logic [NUM_FLAGS-1:0] pend_q;
   logic [NUM_FLAGS-1:0] pend_d;

   assign hit = pend_q[sel] | evt_in[sel];

   always_comb begin
      pend_d = pend_q | evt_in;
      if (probe && hit) begin
         // a stored event is used up; a fresh one in the same cycle stays stored
         pend_d[sel] = pend_q[sel] & evt_in[sel];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   p_pending_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!probe && pend_q[sel]) |=> pend_q[$past(sel)]);

endmodule

// File: rtl/rps_slot_ring.sv
module rps_slot_ring
   import rps_pkg::*;
#(
   parameter int SLOT_COUNT = 4,
   parameter int SLOT_BYTES = 16384,
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter logic [ADDR_W-1:0] TILE_BASE  = '0,
   parameter logic [ADDR_W-1:0] LOCAL_BASE = '0,
   parameter logic [ADDR_W-1:0] CTRL_BASE  = '0,
   localparam int IDX_W = $clog2(SLOT_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  pop_cfg_t          cfg,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr,
   output logic [LEN_W-1:0]  len
);
   localparam logic [ADDR_W-1:0] SLOT_SZ  = ADDR_W'(SLOT_BYTES);
   localparam logic [ADDR_W-1:0] HALF_SZ  = ADDR_W'(SLOT_BYTES / 2);
   localparam logic [LEN_W-1:0]  FULL_LEN = LEN_W'(SLOT_BYTES);
   localparam logic [LEN_W-1:0]  HALF_LEN = LEN_W'(SLOT_BYTES / 2);
   localparam logic [LEN_W-1:0]  WORD_LEN = LEN_W'(4);
   localparam bit IS_POW2 = (SLOT_COUNT & (SLOT_COUNT - 1)) == 0;

   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  idx_nx;
   logic [ADDR_W-1:0] idx_a;
   logic [ADDR_W-1:0] base;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign idx_nx = idx_q + 1'b1;
      end else begin : g_wrap_cmp
         assign idx_nx = (idx_q == IDX_W'(SLOT_COUNT - 1)) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       idx_q <= '0;
      else if (advance) idx_q <= idx_nx;
   end

   assign idx   = idx_q;
   assign idx_a = ADDR_W'(idx_q);
   assign base  = (cfg.mode == MODE_LOCAL) ? LOCAL_BASE : TILE_BASE;

   always_comb begin
      if (cfg.mode == MODE_CTRL) begin
         addr = CTRL_BASE + (idx_a << 2);
         len  = WORD_LEN;
      end else begin
         addr = base + idx_a * SLOT_SZ + ((cfg.split && cfg.sub) ? HALF_SZ : '0);
         len  = cfg.split ? HALF_LEN : FULL_LEN;
      end
   end

   p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, idx_q} < (IDX_W + 1)'(SLOT_COUNT));
   p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(idx_q));

endmodule

// File: rtl/rps_phase_fsm.sv
module rps_phase_fsm
   import rps_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pop_req,
   input  pop_cfg_t cfg_in,
   input  logic     hit,
   input  logic     rd_ack,
   output pop_cfg_t cfg_q,
   output logic     ready,
   output logic     probe,
   output logic     rd_req,
   output logic     free_fire,
   output logic     done,
   output logic     ctrl_cap,
   output logic     in_load
);
   phase_e   state_q, state_d;
   pop_cfg_t cfg_r;
   logic     load_end;

   assign ready     = (state_q == PH_IDLE);
   assign probe     = (state_q == PH_WAIT);
   assign in_load   = (state_q == PH_LOAD);
   assign rd_req    = in_load && (cfg_r.mode != MODE_LOCAL);
   assign free_fire = (state_q == PH_FREE);
   assign done      = (state_q == PH_DONE);
   assign load_end  = in_load && ((cfg_r.mode == MODE_LOCAL) || rd_ack);
   assign ctrl_cap  = in_load && (cfg_r.mode == MODE_CTRL) && rd_ack;
   assign cfg_q     = cfg_r;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PH_IDLE: if (pop_req) state_d = cfg_in.wait_en ? PH_WAIT : PH_LOAD;
         PH_WAIT: if (hit)     state_d = PH_LOAD;
         PH_LOAD: if (load_end) state_d = cfg_r.free_en ? PH_FREE : PH_DONE;
         PH_FREE: state_d = PH_DONE;
         PH_DONE: state_d = PH_IDLE;
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         cfg_r   <= '0;
      end else begin
         state_q <= state_d;
         if (ready && pop_req) cfg_r <= cfg_in;
      end
   end

   p_rd_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> rd_req);
   p_wait_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (probe && !hit) |=> probe);
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && ready));

endmodule

// File: rtl/ring_pop_sequencer.sv
module ring_pop_sequencer
   import rps_pkg::*;
#(
   parameter int NUM_FLAGS  = 32,
   parameter int FLAG_ID    = 2,
   parameter int SLOT_COUNT = 4,
   parameter int SLOT_BYTES = 16384,
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter logic [ADDR_W-1:0] TILE_BASE  = ADDR_W'(32'h0010_0000),
   parameter logic [ADDR_W-1:0] LOCAL_BASE = ADDR_W'(32'h0000_8000),
   parameter logic [ADDR_W-1:0] CTRL_BASE  = ADDR_W'(32'h0000_9000)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pop_req,
   input  logic                 pop_wait_en,
   input  logic                 pop_free_en,
   input  logic [1:0]           pop_mode,
   input  logic                 pop_sub,
   input  logic                 pop_split,
   output logic                 pop_ready,
   output logic                 pop_done,
   input  logic [NUM_FLAGS-1:0] evt_in,
   output logic [NUM_FLAGS-1:0] evt_out,
   output logic                 rd_req,
   output logic [ADDR_W-1:0]    rd_addr,
   output logic [LEN_W-1:0]     rd_len,
   input  logic                 rd_ack,
   input  logic [31:0]          rd_data,
   output logic [ADDR_W-1:0]    slot_addr,
   output logic [31:0]          ctrl_word
);
   localparam int FLAG_W  = $clog2(NUM_FLAGS);
   localparam int IDX_W   = $clog2(SLOT_COUNT);
   localparam int SUB_OFS = 16;
   localparam logic [FLAG_W-1:0] WAIT_S0 = FLAG_W'(FLAG_ID);
   localparam logic [FLAG_W-1:0] WAIT_S1 = FLAG_W'(FLAG_ID + SUB_OFS);
   localparam logic [FLAG_W-1:0] FREE_S0 = FLAG_W'(FLAG_ID + 1);
   localparam logic [FLAG_W-1:0] FREE_S1 = FLAG_W'(FLAG_ID + 1 + SUB_OFS);

   generate
      if (FLAG_ID < 0 || FLAG_ID + 1 + SUB_OFS >= NUM_FLAGS) begin : g_bad_flag
         $error("flag pair with sub-block offset exceeds NUM_FLAGS");
      end
      if (SLOT_COUNT < 2) begin : g_bad_count
         $error("SLOT_COUNT must be at least 2");
      end
      if (SLOT_BYTES < 8 || (SLOT_BYTES % 2) != 0) begin : g_bad_size
         $error("SLOT_BYTES must be even and at least 8");
      end
      if (SLOT_BYTES >= (1 << LEN_W)) begin : g_bad_len
         $error("LEN_W too narrow for SLOT_BYTES");
      end
   endgenerate

   pop_cfg_t           cfg_in, cfg_q;
   logic               hit, probe, free_fire, ctrl_cap, in_load;
   logic [FLAG_W-1:0]  wait_sel, free_sel;
   logic [IDX_W-1:0]   idx;
   logic [ADDR_W-1:0]  ring_addr;
   logic [LEN_W-1:0]   ring_len;
   logic [ADDR_W-1:0]  slot_addr_q;
   logic [31:0]        ctrl_q;

   assign cfg_in.wait_en = pop_wait_en;
   assign cfg_in.free_en = pop_free_en;
   assign cfg_in.mode    = pop_mode_e'(pop_mode);
   assign cfg_in.sub     = pop_sub;
   assign cfg_in.split   = pop_split;

   assign wait_sel = cfg_q.sub ? WAIT_S1 : WAIT_S0;
   assign free_sel = cfg_q.sub ? FREE_S1 : FREE_S0;

   rps_phase_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop_req   (pop_req),
      .cfg_in    (cfg_in),
      .hit       (hit),
      .rd_ack    (rd_ack),
      .cfg_q     (cfg_q),
      .ready     (pop_ready),
      .probe     (probe),
      .rd_req    (rd_req),
      .free_fire (free_fire),
      .done      (pop_done),
      .ctrl_cap  (ctrl_cap),
      .in_load   (in_load)
   );

   rps_event_latch #(.NUM_FLAGS(NUM_FLAGS)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_in (evt_in),
      .sel    (wait_sel),
      .probe  (probe),
      .hit    (hit)
   );

   rps_slot_ring #(
      .SLOT_COUNT (SLOT_COUNT),
      .SLOT_BYTES (SLOT_BYTES),
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .TILE_BASE  (TILE_BASE),
      .LOCAL_BASE (LOCAL_BASE),
      .CTRL_BASE  (CTRL_BASE)
   ) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (pop_done),
      .cfg     (cfg_q),
      .idx     (idx),
      .addr    (ring_addr),
      .len     (ring_len)
   );

   always_comb begin
      evt_out = '0;
      if (free_fire) evt_out[free_sel] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_addr_q <= '0;
         ctrl_q      <= '0;
      end else begin
         if (in_load)  slot_addr_q <= ring_addr;
         if (ctrl_cap) ctrl_q      <= rd_data;
      end
   end

   assign rd_addr   = ring_addr;
   assign rd_len    = ring_len;
   assign slot_addr = slot_addr_q;
   assign ctrl_word = ctrl_q;

   p_evt_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt_out));
   p_evt_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_out) |=> !(|evt_out));
   p_release_then_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_out) |=> pop_done);
   p_idx_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_done |=> (idx != $past(idx)));

endmodule

// File: tb/sim_ring_pop_sequencer.sv
module sim_ring_pop_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int NF    = 32;
   localparam int FID   = 2;
   localparam int SC    = 4;
   localparam int SB    = 16384;
   localparam logic [31:0] TB_TILE  = 32'h0010_0000;
   localparam logic [31:0] TB_LOCAL = 32'h0000_8000;
   localparam logic [31:0] TB_CTRL  = 32'h0000_9000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pop_req = 1'b0, pop_wait_en = 1'b1, pop_free_en = 1'b1;
   logic [1:0] pop_mode = 2'd0;
   logic pop_sub = 1'b0, pop_split = 1'b0;
   logic pop_ready, pop_done;
   logic [NF-1:0] evt_in = '0;
   logic [NF-1:0] evt_out;
   logic rd_req;
   logic [31:0] rd_addr;
   logic [15:0] rd_len;
   logic rd_ack = 1'b0;
   logic [31:0] rd_data = '0;
   logic [31:0] slot_addr, ctrl_word;

   ring_pop_sequencer #(
      .NUM_FLAGS(NF), .FLAG_ID(FID), .SLOT_COUNT(SC), .SLOT_BYTES(SB),
      .ADDR_W(32), .LEN_W(16),
      .TILE_BASE(TB_TILE), .LOCAL_BASE(TB_LOCAL), .CTRL_BASE(TB_CTRL)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pop_req(pop_req), .pop_wait_en(pop_wait_en),
      .pop_free_en(pop_free_en), .pop_mode(pop_mode), .pop_sub(pop_sub),
      .pop_split(pop_split), .pop_ready(pop_ready), .pop_done(pop_done),
      .evt_in(evt_in), .evt_out(evt_out), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_len(rd_len), .rd_ack(rd_ack), .rd_data(rd_data),
      .slot_addr(slot_addr), .ctrl_word(ctrl_word)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit started = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int m_ph = 0;        // 0 idle,1 wait,2 transfer,3 release,4 done
   int m_cnt = 0;
   bit [NF-1:0] m_pend = '0;
   bit m_wait, m_free, m_sub, m_split;
   int m_mode = 0;
   logic [31:0] m_ctrl = '0;

   function automatic int wflag(bit s); return FID + (s ? 16 : 0); endfunction
   function automatic int fflag(bit s); return FID + 1 + (s ? 16 : 0); endfunction

   function automatic logic [31:0] m_addr(int idx, int mode, bit s, bit sp);
      logic [31:0] a;
      if (mode == 2) return TB_CTRL + 32'(idx * 4);
      a = ((mode == 1) ? TB_LOCAL : TB_TILE) + 32'(idx * SB);
      if (sp && s) a = a + 32'(SB / 2);
      return a;
   endfunction

   function automatic int m_len(int mode, bit sp);
      if (mode == 2) return 4;
      return sp ? SB / 2 : SB;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_pend = '0; m_ctrl = '0;
      end else begin
         bit [NF-1:0] old_pend;
         old_pend = m_pend;
         m_pend = m_pend | evt_in;
         case (m_ph)
            0: if (pop_req) begin
                  m_wait = pop_wait_en; m_free = pop_free_en; m_mode = int'(pop_mode);
                  m_sub = pop_sub; m_split = pop_split;
                  m_ph = m_wait ? 1 : 2;
               end
            1: begin
                  int w;
                  w = wflag(m_sub);
                  if (old_pend[w] || evt_in[w]) begin
                     m_pend[w] = old_pend[w] && evt_in[w];
                     m_ph = 2;
                  end
               end
            2: if (m_mode == 1) m_ph = m_free ? 3 : 4;
               else if (rd_ack) begin
                  if (m_mode == 2) m_ctrl = rd_data;
                  m_ph = m_free ? 3 : 4;
               end
            3: m_ph = 4;
            default: begin m_ph = 0; m_cnt++; end
         endcase
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && started) begin
         logic [NF-1:0] e_evt;
         int mm;
         mm = (m_mode == 3) ? 0 : m_mode;
         e_evt = '0;
         if (m_ph == 3) e_evt[fflag(m_sub)] = 1'b1;
         chk(pop_ready == (m_ph == 0), "R1", "pop_ready", pop_ready, m_ph == 0);
         chk(rd_req == (m_ph == 2 && mm != 1), "R10", "rd_req", rd_req, (m_ph == 2 && mm != 1));
         chk(evt_out == e_evt, "R3", "evt_out", evt_out, e_evt);
         chk(pop_done == (m_ph == 4), "R11", "pop_done", pop_done, m_ph == 4);
         chk(ctrl_word == m_ctrl, "R9", "ctrl_word", ctrl_word, m_ctrl);
         if (rd_req) begin
            chk(rd_addr == m_addr(m_cnt % SC, mm, m_sub, m_split),
                m_split ? "R5" : (mm == 2 ? "R9" : "R4"), "rd_addr",
                rd_addr, m_addr(m_cnt % SC, mm, m_sub, m_split));
            chk(int'(rd_len) == m_len(mm, m_split), m_split ? "R5" : "R4", "rd_len",
                rd_len, m_len(mm, m_split));
         end
         if (pop_done)
            chk(slot_addr == m_addr(m_cnt % SC, mm, m_sub, m_split), "R10", "slot_addr",
                slot_addr, m_addr(m_cnt % SC, mm, m_sub, m_split));
      end
   end

   // ---------------- memory responder ----------------
   int ack_lat = 1;
   int lat_cnt = 0;
   logic [31:0] last_data = '0;
   always @(negedge clk) begin
      if (rd_ack) begin
         rd_ack = 1'b0;
      end else if (rd_req) begin
         if (lat_cnt >= ack_lat) begin
            rd_ack = 1'b1;
            rd_data = $urandom;
            last_data = rd_data;
            lat_cnt = 0;
         end else lat_cnt++;
      end
   end

   // ---------------- stimulus ----------------
   bit saw_evt, saw_rd, saw_done, first_rd;

   // delay >= 0: ready event that many cycles after acceptance; -1: none
   task automatic do_pop(input bit we, input bit fe, input int mode, input bit s,
                         input bit sp, input int delay);
      int n;
      @(negedge clk);
      pop_wait_en = we; pop_free_en = fe; pop_mode = 2'(mode);
      pop_sub = s; pop_split = sp; pop_req = 1'b1;
      @(negedge clk);
      pop_req = 1'b0;
      first_rd = rd_req;
      saw_evt = 0; saw_rd = rd_req; saw_done = 0;
      n = 0;
      while (!pop_done && n < 300) begin
         evt_in = '0;
         if (n == delay) evt_in[wflag(s)] = 1'b1;
         @(negedge clk);
         n++;
         if (|evt_out) saw_evt = 1;
         if (rd_req) saw_rd = 1;
      end
      evt_in = '0;
      saw_done = pop_done;
      chk(saw_done, "R1", "pop completed", saw_done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pop_ready == 1'b1, "R11", "reset pop_ready", pop_ready, 1);
      chk(evt_out == '0, "R11", "reset evt_out", evt_out, 0);
      chk(rd_req == 1'b0, "R11", "reset rd_req", rd_req, 0);
      chk(pop_done == 1'b0, "R11", "reset pop_done", pop_done, 0);
      chk(ctrl_word == '0, "R9", "reset ctrl_word", ctrl_word, 0);
      started = 1;

      ack_lat = 2;
      do_pop(1, 1, 0, 0, 0, 3);
      chk(saw_evt, "R3", "release seen", saw_evt, 1);

      // R8: event before the pop, none during it
      @(negedge clk); evt_in[FID] = 1'b1;
      @(negedge clk); evt_in = '0;
      repeat (3) @(negedge clk);
      do_pop(1, 1, 0, 0, 0, -1);
      chk(saw_done, "R8", "pending event consumed", saw_done, 1);

      do_pop(1, 1, 0, 1, 1, 2);
      do_pop(1, 1, 0, 0, 1, 1);

      // R6: wait skipped, transfer right after acceptance
      do_pop(0, 1, 0, 0, 0, -1);
      chk(first_rd, "R6", "rd_req one cycle after accept", first_rd, 1);

      // R7: release skipped
      do_pop(1, 0, 0, 0, 0, 1);
      chk(!saw_evt, "R7", "no release event", saw_evt, 0);

      // R9: control word
      ack_lat = 1;
      do_pop(1, 1, 2, 0, 0, 0);
      @(negedge clk);
      chk(ctrl_word == last_data, "R9", "ctrl_word latched", ctrl_word, last_data);

      // R10: direct local, no read
      do_pop(1, 1, 1, 1, 1, 2);
      chk(!saw_rd, "R10", "no read in local mode", saw_rd, 0);

      // R2: indefinite wait, wrong-flag events do not end it
      begin
         bit done_seen;
         done_seen = 0;
         @(negedge clk);
         pop_wait_en = 1; pop_free_en = 1; pop_mode = 0; pop_sub = 0; pop_split = 0;
         pop_req = 1'b1;
         @(negedge clk);
         pop_req = 1'b0;
         for (int i = 0; i < 60; i++) begin
            evt_in = '0;
            if (i == 10) evt_in[FID + 16] = 1'b1;
            if (i == 20) evt_in[FID + 1] = 1'b1;
            if (i == 30) pop_req = 1'b1;
            if (i == 31) pop_req = 1'b0;
            @(negedge clk);
            if (pop_done || rd_req) done_seen = 1;
         end
         evt_in = '0;
         chk(!done_seen, "R2", "still waiting", done_seen, 0);
         chk(!pop_ready, "R2", "busy while waiting", pop_ready, 0);
         evt_in[FID] = 1'b1;
         @(negedge clk);
         evt_in = '0;
         while (!pop_done) @(negedge clk);
         @(negedge clk);
         chk(pop_ready, "R11", "ready after done", pop_ready, 1);
      end

      // sub-block 1 pop uses the flag latched during the wait above
      do_pop(1, 1, 0, 1, 0, -1);
      chk(saw_done, "R8", "sub1 pending consumed", saw_done, 1);
      chk(saw_evt, "R3", "sub1 release", saw_evt, 1);

      // R1: request held high, back-to-back pops
      ack_lat = 0;
      @(negedge clk);
      pop_wait_en = 0; pop_free_en = 1; pop_mode = 0; pop_sub = 0; pop_split = 0;
      pop_req = 1'b1;
      repeat (40) @(negedge clk);
      pop_req = 1'b0;
      while (!pop_ready) @(negedge clk);

      // R4: several ring turns
      for (int k = 0; k < 6; k++) begin
         ack_lat = k % 3;
         do_pop(1, k % 2 == 0, (k == 4) ? 3 : 0, k[0], k[1], k % 4);
      end
      repeat (3) @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired, no completion: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule